// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt unit of a small microcontroller. It keeps one pending flag and one enable bit for each interrupt source, along with a global interrupt enable. Sources are edge/event sources by default; any source chosen through a parameter mask is level-sensitive instead. A level-sensitive source has no flag and requests service only while its input is high. An event source latches a flag whether or not it is enabled, and the flag stays set until that source is serviced or software clears it.

The block talks to a simple core through a handshake. The core gives an instruction-boundary strobe, a sleep indicator, its current 9-bit program counter and a return-from-interrupt request. The block can accept a request only when the global enable is set, when the core is at an instruction boundary or asleep, and when the mandatory post-return instruction has already run. On acceptance it runs a fixed entry sequence of 4 cycles, or 8 if the core was asleep. During that sequence it pushes the program counter to an external stack port, clears the global enable and the serviced flag, and presents the handler vector. A return runs a fixed 4-cycle sequence: it pops the saved counter, restores it, and sets the global enable again. After a return, one main-program instruction must finish before any pending request is taken.

Priority is fixed, and the lowest source index wins. The vector address is the source index plus one, so address 0 stays free for reset. The block saves no status. `rst_n` asserts asynchronously and must already be released in step with `clk`.

Top module: `irq_sequencer`

## Requirements
- R1: While reset is asserted, and just after it, `gie`, `flags`, `busy`, `push_valid`, `pop_req`, `ret_valid` and `vector_valid` are all 0, and all enables are clear.
- R2: A high `src_in[i]` on an event source sets `flags[i]` at the next clock, whatever the enables and `gie` are. The flag then stays set until it is cleared, and enable writes do not change it.
- R3: A `flag_clr_wr` cycle clears each flag whose bit in `flag_clr_data` is 1. If an event sets the same flag in the same cycle, the set wins.
- R4: A level source (bit set in `LEVEL_MASK`, default source 0) always reads 0 in `flags`. It requests service only during the cycles its input is high, so a pulse that ends before a boundary is lost.
- R5: A request is accepted at a clock where all of these hold: `gie`=1, the block is idle, no return is requested, the post-return gap is clear, some enabled source is pending, and `instr_done` or `sleeping` is 1. The lowest pending enabled index wins, and `vector_addr` = index + 1.
- R6: After acceptance, `push_valid` is high for exactly the first entry cycle, with `push_data` equal to the `pc_in` value sampled at acceptance. `vector_valid` is high in the 4th entry cycle. The serviced flag is cleared, and all other flags are kept.
- R7: If `sleeping` is 1 at acceptance, `vector_valid` comes in the 8th entry cycle instead.
- R8: Acceptance clears `gie`. While `gie`=0, pending enabled requests with `instr_done` are not accepted. `gie_set` and `gie_clr` set and clear `gie` from software.
- R9: A `reti_req` while idle starts a 4-cycle return. `pop_req` is high in the first return cycle. `pop_data` is sampled in the second cycle. `ret_valid` and `ret_pc` appear in the 4th cycle, and `gie` reads 1 from the next cycle on.
- R10: After a return, the first `instr_done` does not accept a request, even if one is pending and enabled. A later boundary can accept it.
- R11: When several flags are pending, they are serviced one per entry in ascending index order, and lower-priority flags persist across the first entry and return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| src_in | input | N_SRC | Event pulses (event sources) or request levels (level sources) |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wdata | input | N_SRC | New enable mask |
| flag_clr_wr | input | 1 | Write strobe for flag clearing |
| flag_clr_data | input | N_SRC | One per flag to clear |
| gie_set | input | 1 | Software sets the global enable |
| gie_clr | input | 1 | Software clears the global enable |
| instr_done | input | 1 | Core is at an instruction boundary |
| sleeping | input | 1 | Core is in sleep mode |
| pc_in | input | PC_W | Current program counter |
| reti_req | input | 1 | Core executes a return from interrupt |
| pop_data | input | PC_W | Stack read data, valid from the cycle after `pop_req` |
| gie | output | 1 | Global interrupt enable |
| flags | output | N_SRC | Pending flags (level sources read 0) |
| busy | output | 1 | Entry or return sequence in progress |
| push_valid | output | 1 | Stack push strobe |
| push_data | output | PC_W | Program counter being pushed |
| pop_req | output | 1 | Stack pop strobe |
| ret_valid | output | 1 | Return address valid |
| ret_pc | output | PC_W | Restored program counter |
| vector_valid | output | 1 | Handler vector valid |
| vector_addr | output | PC_W | Handler vector address |

## Verification
Inputs change on falling edges and outputs are read on the falling edge that follows, so each result has a fixed latency in cycles. Flag changes show one cycle after the pulse or clear. For a stimulus at the accepting edge, `push_valid` is due 1 cycle later and `vector_valid` 4 cycles later (8 when asleep). For a return, `pop_req` is due 1 cycle after `reti_req`, `ret_valid` 4 cycles after it, and `gie` one cycle after `ret_valid`. The bench counts falling edges from each stimulus and compares the count at which each strobe appears with these numbers, instead of waiting on an open-ended condition.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_ENTRY  = 2'd1,
    SQ_RETURN = 2'd2
  } sq_state_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N_SRC = 4,
  parameter logic [N_SRC-1:0] LEVEL_MASK = 4'b0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_wdata,
  input  logic             clr_wr,
  input  logic [N_SRC-1:0] clr_data,
  input  logic [N_SRC-1:0] hw_clr,
  output logic [N_SRC-1:0] flags,
  output logic [N_SRC-1:0] req
);
  logic [N_SRC-1:0] en_q, en_n;
  logic [N_SRC-1:0] pend;

  always_comb begin
    en_n = en_q;
    if (en_wr) en_n = en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_n;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_lvl
      // no storage: request follows the input level
      logic unused_lvl;
      assign unused_lvl = hw_clr[i] ^ clr_data[i];
      assign flags[i]   = 1'b0;
      assign pend[i]    = src_in[i];
    end else begin : g_evt
      logic f_q, f_n;
      always_comb begin
        f_n = f_q;
        if (hw_clr[i])              f_n = 1'b0;
        if (clr_wr && clr_data[i])  f_n = 1'b0;
        if (src_in[i])              f_n = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= 1'b0;
        else        f_q <= f_n;
      end
      assign flags[i] = f_q;
      assign pend[i]  = f_q;
    end
  end

  assign req = pend & en_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 4,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N_SRC-1:0] onehot
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx       = IDX_W'(i);
        onehot    = '0;
        onehot[i] = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_pkg::*;
#(
  parameter int PC_W      = 9,
  parameter int IDX_W     = 2,
  parameter int ENTRY_CYC = 4,
  parameter int SLEEP_CYC = 4,
  parameter int RET_CYC   = 4,
  localparam int LONG_CYC = ENTRY_CYC + SLEEP_CYC,
  localparam int MAX_CYC  = (LONG_CYC > RET_CYC) ? LONG_CYC : RET_CYC,
  localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_req,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             instr_done,
  input  logic             sleeping,
  input  logic [PC_W-1:0]  pc_in,
  input  logic             reti_req,
  input  logic [PC_W-1:0]  pop_data,
  output logic             take,
  output logic             gie,
  output logic             busy,
  output logic             push_valid,
  output logic [PC_W-1:0]  push_data,
  output logic             pop_req,
  output logic             ret_valid,
  output logic [PC_W-1:0]  ret_pc,
  output logic             vector_valid,
  output logic [PC_W-1:0]  vector_addr
);
  sq_state_t        state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             first_q, first_n;
  logic             gie_q, gie_n;
  logic             gap_q, gap_n;
  logic [PC_W-1:0]  pc_q, pc_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             idle, ret_go, last;

  assign idle   = (state_q == SQ_IDLE);
  assign ret_go = idle && reti_req;
  assign take   = idle && !reti_req && gie_q && !gap_q && any_req &&
                  (instr_done || sleeping);
  assign last   = (cnt_q == '0);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    first_n = 1'b0;
    pc_n    = pc_q;
    idx_n   = idx_q;
    gap_n   = gap_q;
    gie_n   = gie_q;
    if (gie_set)      gie_n = 1'b1;
    else if (gie_clr) gie_n = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (instr_done) gap_n = 1'b0;
        if (ret_go) begin
          state_n = SQ_RETURN;
          cnt_n   = CNT_W'(RET_CYC - 1);
          first_n = 1'b1;
        end else if (take) begin
          state_n = SQ_ENTRY;
          cnt_n   = sleeping ? CNT_W'(LONG_CYC - 1) : CNT_W'(ENTRY_CYC - 1);
          first_n = 1'b1;
          pc_n    = pc_in;
          idx_n   = pick_idx;
          gie_n   = 1'b0;
        end
      end
      SQ_ENTRY: begin
        if (last) state_n = SQ_IDLE;
        else      cnt_n   = cnt_q - 1'b1;
      end
      SQ_RETURN: begin
        if (cnt_q == CNT_W'(RET_CYC - 2)) pc_n = pop_data;
        if (last) begin
          state_n = SQ_IDLE;
          gap_n   = 1'b1;
          gie_n   = 1'b1;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b0;
      gie_q   <= 1'b0;
      gap_q   <= 1'b0;
      pc_q    <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      first_q <= first_n;
      gie_q   <= gie_n;
      gap_q   <= gap_n;
      pc_q    <= pc_n;
      idx_q   <= idx_n;
    end
  end

  assign gie          = gie_q;
  assign busy         = !idle;
  assign push_valid   = (state_q == SQ_ENTRY) && first_q;
  assign push_data    = pc_q;
  assign pop_req      = (state_q == SQ_RETURN) && first_q;
  assign ret_valid    = (state_q == SQ_RETURN) && last;
  assign ret_pc       = pc_q;
  assign vector_valid = (state_q == SQ_ENTRY) && last;
  assign vector_addr  = vector_valid ? (PC_W'(idx_q) + PC_W'(1)) : '0;
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int N_SRC = 4,
  parameter logic [N_SRC-1:0] LEVEL_MASK = 4'b0001,
  parameter int PC_W      = 9,
  parameter int ENTRY_CYC = 4,
  parameter int SLEEP_CYC = 4,
  parameter int RET_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_wdata,
  input  logic             flag_clr_wr,
  input  logic [N_SRC-1:0] flag_clr_data,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             instr_done,
  input  logic             sleeping,
  input  logic [PC_W-1:0]  pc_in,
  input  logic             reti_req,
  input  logic [PC_W-1:0]  pop_data,
  output logic             gie,
  output logic [N_SRC-1:0] flags,
  output logic             busy,
  output logic             push_valid,
  output logic [PC_W-1:0]  push_data,
  output logic             pop_req,
  output logic             ret_valid,
  output logic [PC_W-1:0]  ret_pc,
  output logic             vector_valid,
  output logic [PC_W-1:0]  vector_addr
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] req, onehot, hw_clr;
  logic             any_req, take;
  logic [IDX_W-1:0] pick_idx;

  assign hw_clr = take ? onehot : '0;

  irq_src_bank #(.N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .clr_wr(flag_clr_wr), .clr_data(flag_clr_data),
    .hw_clr(hw_clr), .flags(flags), .req(req)
  );

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .req(req), .any(any_req), .idx(pick_idx), .onehot(onehot)
  );

  irq_seq_fsm #(
    .PC_W(PC_W), .IDX_W(IDX_W), .ENTRY_CYC(ENTRY_CYC),
    .SLEEP_CYC(SLEEP_CYC), .RET_CYC(RET_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .any_req(any_req), .pick_idx(pick_idx),
    .gie_set(gie_set), .gie_clr(gie_clr), .instr_done(instr_done),
    .sleeping(sleeping), .pc_in(pc_in), .reti_req(reti_req),
    .pop_data(pop_data), .take(take), .gie(gie), .busy(busy),
    .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .vector_valid(vector_valid),
    .vector_addr(vector_addr)
  );
endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic gie,
  input logic gie_set,
  input logic busy,
  input logic push_valid,
  input logic pop_req,
  input logic ret_valid,
  input logic vector_valid
);
  // R8
  gie_off_at_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> !gie);

  // R6
  push_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> (!push_valid && busy));

  // R6
  no_stack_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_valid && pop_req) && !(vector_valid && ret_valid));

  // R9
  gie_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gie) |-> ($past(ret_valid) || $past(gie_set)));

  // R9
  ret_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !busy);

  // R10
  gap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !push_valid);

  // R10
  gap_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> ##1 !push_valid);
endmodule

bind irq_sequencer irq_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .gie_set(gie_set), .busy(busy),
  .push_valid(push_valid), .pop_req(pop_req), .ret_valid(ret_valid),
  .vector_valid(vector_valid)
);

// File: tb/tb_irq_sequencer.sv
module tb_irq_sequencer;
  localparam int N = 4;
  localparam int PW = 9;
  localparam logic [N-1:0] LVL = 4'b0001;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] src_in, en_wdata, flag_clr_data, flags;
  logic en_wr, flag_clr_wr, gie_set, gie_clr, instr_done, sleeping, reti_req;
  logic [PW-1:0] pc_in, pop_data, push_data, ret_pc, vector_addr;
  logic gie, busy, push_valid, pop_req, ret_valid, vector_valid;

  int checks = 0;
  int fails = 0;
  int cyc_cnt = 0;

  irq_sequencer dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .en_wr(en_wr),
    .en_wdata(en_wdata), .flag_clr_wr(flag_clr_wr),
    .flag_clr_data(flag_clr_data), .gie_set(gie_set), .gie_clr(gie_clr),
    .instr_done(instr_done), .sleeping(sleeping), .pc_in(pc_in),
    .reti_req(reti_req), .pop_data(pop_data), .gie(gie), .flags(flags),
    .busy(busy), .push_valid(push_valid), .push_data(push_data),
    .pop_req(pop_req), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .vector_valid(vector_valid), .vector_addr(vector_addr)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 50000) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int low_idx(logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return i;
    return -1;
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic quiet();
    src_in = '0; en_wr = 0; en_wdata = '0; flag_clr_wr = 0; flag_clr_data = '0;
    gie_set = 0; gie_clr = 0; instr_done = 0; sleeping = 0; reti_req = 0;
  endtask

  // one full acceptance; returns the serviced index through the checks
  task automatic run_entry(logic [N-1:0] fl, logic [N-1:0] en, bit lvl,
                           bit slp, logic [PW-1:0] pc);
    logic [N-1:0] rq, fexp;
    int exp_i, n, lat;
    fexp  = fl & ~LVL;
    rq    = (fexp | (lvl ? LVL : '0)) & en;
    exp_i = low_idx(rq);
    lat   = slp ? 8 : 4;
    // clear gap, gie and flags
    quiet(); gie_clr = 1; flag_clr_wr = 1; flag_clr_data = '1; instr_done = 1;
    cyc(); quiet();
    src_in = fexp | (lvl ? LVL : '0); en_wr = 1; en_wdata = en;
    cyc(); quiet(); src_in = lvl ? LVL : '0;
    chk("R2 flags latched", int'(flags), int'(fexp));
    instr_done = 1;
    cyc(); instr_done = 0;
    chk("R8 no accept with gie=0", int'(push_valid), 0);
    gie_set = 1;
    cyc(); gie_set = 0;
    chk("R8 gie_set", int'(gie), 1);
    pc_in = pc; instr_done = !slp; sleeping = slp;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      cyc(); quiet(); n++;
      if (n == 1) begin
        chk("R6 push strobe", int'(push_valid), 1);
        chk("R6 push data", int'(push_data), int'(pc));
      end
      if (vector_valid) break;
    end
    chk(slp ? "R7 sleep entry latency" : "R6 entry latency", n, lat);
    chk("R5 vector addr", int'(vector_addr), exp_i + 1);
    cyc();
    chk("R8 gie cleared", int'(gie), 0);
    chk("R6 busy done", int'(busy), 0);
    if (exp_i >= 0) fexp[exp_i] = 1'b0;
    chk("R6 serviced flag cleared, others kept", int'(flags), int'(fexp));
  endtask

  task automatic run_return(logic [PW-1:0] pd);
    int n;
    quiet(); reti_req = 1; pop_data = pd;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      cyc(); reti_req = 0; n++;
      if (n == 1) chk("R9 pop strobe", int'(pop_req), 1);
      if (ret_valid) break;
    end
    chk("R9 return latency", n, 4);
    chk("R9 ret pc", int'(ret_pc), int'(pd));
    cyc();
    chk("R9 gie restored", int'(gie), 1);
  endtask

  initial begin
    logic [N-1:0] fexp, fl, en, ev, cd;
    bit cw, lv;
    int n;
    void'($urandom(32'd20240611));
    quiet(); pc_in = '0; pop_data = '0; rst_n = 0;
    repeat (3) cyc();
    chk("R1 gie in reset", int'(gie), 0);
    chk("R1 flags in reset", int'(flags), 0);
    rst_n = 1;
    cyc();
    chk("R1 busy", int'(busy), 0);
    chk("R1 strobes", int'({push_valid, pop_req, ret_valid, vector_valid}), 0);
    instr_done = 1; src_in = LVL;
    cyc(); quiet();
    chk("R1 enables clear, no accept", int'(push_valid), 0);

    // random flag traffic with gie off
    fexp = '0;
    for (int k = 0; k < 150; k++) begin
      ev = N'($urandom); cw = $urandom % 3 == 0; cd = N'($urandom);
      src_in = ev; flag_clr_wr = cw; flag_clr_data = cd;
      en_wr = $urandom % 2; en_wdata = N'($urandom);
      cyc();
      fexp = (fexp & ~(cw ? cd : '0)) | (ev & ~LVL);
      chk("R2 R3 flag model", int'(flags), int'(fexp));
    end
    quiet();
    src_in = 4'b0100; flag_clr_wr = 1; flag_clr_data = 4'b0110;
    cyc(); quiet();
    chk("R3 set wins over clear", int'(flags & 4'b0110), 4'b0100);
    flag_clr_wr = 1; flag_clr_data = '1;
    cyc(); quiet();
    chk("R3 clear all", int'(flags), 0);

    // level source pulse lost before a boundary
    en_wr = 1; en_wdata = '1; gie_set = 1; src_in = LVL;
    cyc(); quiet();
    chk("R4 level has no flag", int'(flags[0]), 0);
    cyc();
    instr_done = 1;
    cyc(); quiet();
    chk("R4 dropped level not taken", int'(push_valid), 0);
    chk("R4 idle", int'(busy), 0);
    gie_clr = 1;
    cyc(); quiet();

    // random entries and returns
    for (int t = 0; t < 24; t++) begin
      do begin
        fl = N'($urandom); en = N'($urandom); lv = $urandom % 2;
      end while ((((fl & ~LVL) | (lv ? LVL : '0)) & en) == '0);
      run_entry(fl, en, lv, (t % 3) == 1, PW'($urandom));
      run_return(PW'($urandom));
    end

    // directed: post-return gap and ordered service
    run_entry(4'b1010, 4'b1111, 1'b0, 1'b0, 9'h155);
    run_return(9'h0AA);
    instr_done = 1;
    cyc(); quiet();
    chk("R10 first boundary after return ignored", int'(push_valid), 0);
    instr_done = 1;
    cyc(); quiet();
    chk("R10 second boundary accepts", int'(push_valid), 1);
    n = 1;
    for (int k = 0; k < 20; k++) begin
      if (vector_valid) break;
      cyc(); n++;
    end
    chk("R11 next priority latency", n, 4);
    chk("R11 next priority vector", int'(vector_addr), 4);
    cyc();
    chk("R11 all flags serviced", int'(flags), 0);
    run_return(9'h1FF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule